// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block watches one execution context's load-linked / store-conditional pairs. A load-linked request records a reservation: a valid flag and the physical address rounded down to a 16-byte granule. A coherence snoop that lands in the same cache line as the reservation clears it. A store-conditional is judged against the reservation. The block replies whether the store may be forwarded to memory, and with a result code for the destination register.

Uncacheable store-conditionals bypass the check. Cacheable ones must hit a live reservation in the same 16-byte granule. A counter tracks consecutive failed store-conditionals and emits a one-cycle warning pulse on every `WARN_PERIOD`-th consecutive failure. This lets a core or debug fabric spot a livelocked atomic loop. The verdict is registered and appears one cycle after the request strobe.

Top module: `llsc_resv_monitor`

## Requirements
- R1: Reset clears the reservation flag and the consecutive-failure count, and holds every output at zero. A cacheable store-conditional issued straight after reset therefore fails.
- R2: A load-linked request stores its address with the low 4 bits zeroed and sets the reservation flag. A load-linked request in the same cycle as a snoop to the same line still leaves the reservation set.
- R3: A snoop clears the reservation when the flag is set and the two addresses agree above the line offset (address divided by `LINE_BYTES`, 64 by default). A snoop to another line, or any snoop while the flag is clear, changes nothing.
- R4: An uncacheable store-conditional returns code 2 (keep destination) with forward=1. It leaves the reservation and the failure count untouched.
- R5: A cacheable store-conditional fails when the flag is clear or its 16-byte granule differs from the stored one. A failure returns code 0 with forward=0 and clears the flag.
- R6: A cacheable store-conditional that matches a live reservation returns code 1 with forward=1. It keeps the reservation and sets the consecutive-failure count to zero.
- R7: `sc_resp_valid` is high for exactly the cycle after each store-conditional strobe. In every other cycle, `sc_forward` and `sc_code` are 0.
- R8: Each failure adds one to the consecutive-failure count. `livelock_warn` pulses for one cycle, together with the failing verdict, whenever the count reaches a nonzero multiple of `WARN_PERIOD`.
- R9: When a snoop and a cacheable store-conditional hit the same reserved line in one cycle, the snoop wins and the store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_addr | input | PADDR_W | Physical address of the load-linked |
| sc_valid | input | 1 | Store-conditional request strobe |
| sc_addr | input | PADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| snoop_valid | input | 1 | Coherence snoop strobe |
| snoop_addr | input | PADDR_W | Snooped physical address |
| sc_resp_valid | output | 1 | Verdict valid, one cycle after `sc_valid` |
| sc_forward | output | 1 | Store may be sent to memory |
| sc_code | output | 2 | Result code: 0 fail, 1 success, 2 keep destination |
| livelock_warn | output | 1 | One-cycle consecutive-failure warning |

## Verification
The assertions assume the context never issues a load-linked and a store-conditional in the same cycle, since one pipeline slot carries either. The checker states this as an input rule. The bench's directed and random stimulus never raises both strobes together, while snoops are freely overlaid on either request. The random phase draws addresses from a small set that shares and splits granules and lines, so matches and mismatches at both granularities occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    SC_CODE_FAIL   = 2'd0,
    SC_CODE_DONE   = 2'd1,
    SC_CODE_BYPASS = 2'd2
  } sc_code_e;

  typedef struct packed {
    logic     fire;
    logic     forward;
    sc_code_e code;
  } sc_verdict_t;

  localparam sc_verdict_t VERDICT_IDLE = '{fire: 1'b0, forward: 1'b0, code: SC_CODE_FAIL};

endpackage

// File: rtl/resv_store.sv
module resv_store #(
  parameter int PADDR_W  = 40,
  parameter int GRAN_LG2 = 4,
  parameter int LINE_LG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ll_valid,
  input  logic [PADDR_W-1:0] ll_addr,
  input  logic               snoop_valid,
  input  logic [PADDR_W-1:0] snoop_addr,
  input  logic               kill_req,
  output logic               resv_valid,
  output logic [PADDR_W-1:0] resv_addr,
  output logic               snoop_hit,
  output logic               flag_live
);

  localparam logic [PADDR_W-1:0] GRAN_MASK = (PADDR_W'(1) << GRAN_LG2) - PADDR_W'(1);

  function automatic logic [PADDR_W-1:0] granule_base(input logic [PADDR_W-1:0] a);
    return a & ~GRAN_MASK;
  endfunction

  function automatic logic same_line(input logic [PADDR_W-1:0] a, input logic [PADDR_W-1:0] b);
    return (a >> LINE_LG2) == (b >> LINE_LG2);
  endfunction

  // snoop only matters while a reservation is held
  assign snoop_hit = resv_valid && snoop_valid && same_line(snoop_addr, resv_addr);
  // flag as seen by a store-conditional in this cycle: snoop has priority
  assign flag_live = resv_valid && !snoop_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (ll_valid) begin
      resv_valid <= 1'b1;
      resv_addr  <= granule_base(ll_addr);
    end else if (kill_req || snoop_hit) begin
      resv_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_judge.sv
module sc_judge #(
  parameter int PADDR_W  = 40,
  parameter int GRAN_LG2 = 4
) (
  input  logic                     sc_valid,
  input  logic                     sc_uncached,
  input  logic [PADDR_W-1:0]       sc_addr,
  input  logic                     flag_live,
  input  logic [PADDR_W-1:0]       resv_addr,
  output llsc_pkg::sc_verdict_t    verdict,
  output logic                     fail_evt,
  output logic                     pass_evt
);
  import llsc_pkg::*;

  function automatic logic same_granule(input logic [PADDR_W-1:0] a, input logic [PADDR_W-1:0] b);
    return (a >> GRAN_LG2) == (b >> GRAN_LG2);
  endfunction

  logic cached_req;
  logic match;

  assign cached_req = sc_valid && !sc_uncached;
  assign match      = flag_live && same_granule(sc_addr, resv_addr);
  assign pass_evt   = cached_req && match;
  assign fail_evt   = cached_req && !match;

  always_comb begin
    verdict = VERDICT_IDLE;
    if (sc_valid) begin
      verdict.fire = 1'b1;
      if (sc_uncached) begin
        verdict.forward = 1'b1;
        verdict.code    = SC_CODE_BYPASS;
      end else if (match) begin
        verdict.forward = 1'b1;
        verdict.code    = SC_CODE_DONE;
      end
    end
  end

endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic pass_evt,
  output logic warn_evt
);

  localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);

  // position of the failure count within the current warning period
  logic [PH_W-1:0] phase;

  function automatic logic [PH_W-1:0] phase_next(input logic [PH_W-1:0] p);
    return (p == PH_LAST) ? '0 : p + PH_W'(1);
  endfunction

  assign warn_evt = fail_evt && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (pass_evt) begin
      phase <= '0;
    end else if (fail_evt) begin
      phase <= phase_next(phase);
    end
  end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int PADDR_W       = 40,
  parameter int LINE_BYTES    = 64,
  parameter int GRANULE_BYTES = 16,
  parameter int WARN_PERIOD   = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ll_valid,
  input  logic [PADDR_W-1:0] ll_addr,
  input  logic               sc_valid,
  input  logic [PADDR_W-1:0] sc_addr,
  input  logic               sc_uncached,
  input  logic               snoop_valid,
  input  logic [PADDR_W-1:0] snoop_addr,
  output logic               sc_resp_valid,
  output logic               sc_forward,
  output logic [1:0]         sc_code,
  output logic               livelock_warn
);
  import llsc_pkg::*;

  localparam int LINE_LG2 = $clog2(LINE_BYTES);
  localparam int GRAN_LG2 = $clog2(GRANULE_BYTES);

  logic               resv_valid;
  logic [PADDR_W-1:0] resv_addr;
  logic               snoop_hit;
  logic               flag_live;
  logic               fail_evt;
  logic               pass_evt;
  logic               warn_evt;
  sc_verdict_t        verdict;

  resv_store #(.PADDR_W(PADDR_W), .GRAN_LG2(GRAN_LG2), .LINE_LG2(LINE_LG2)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ll_valid   (ll_valid),
    .ll_addr    (ll_addr),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .kill_req   (fail_evt),
    .resv_valid (resv_valid),
    .resv_addr  (resv_addr),
    .snoop_hit  (snoop_hit),
    .flag_live  (flag_live)
  );

  sc_judge #(.PADDR_W(PADDR_W), .GRAN_LG2(GRAN_LG2)) u_judge (
    .sc_valid   (sc_valid),
    .sc_uncached(sc_uncached),
    .sc_addr    (sc_addr),
    .flag_live  (flag_live),
    .resv_addr  (resv_addr),
    .verdict    (verdict),
    .fail_evt   (fail_evt),
    .pass_evt   (pass_evt)
  );

  fail_tracker #(.WARN_PERIOD(WARN_PERIOD)) u_fails (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail_evt(fail_evt),
    .pass_evt(pass_evt),
    .warn_evt(warn_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_resp_valid <= 1'b0;
      sc_forward    <= 1'b0;
      sc_code       <= 2'd0;
      livelock_warn <= 1'b0;
    end else begin
      sc_resp_valid <= verdict.fire;
      sc_forward    <= verdict.forward;
      sc_code       <= verdict.code;
      livelock_warn <= warn_evt;
    end
  end

endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
  parameter int PADDR_W     = 40,
  parameter int GRAN_LG2    = 4,
  parameter int WARN_PERIOD = 100000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ll_valid,
  input logic               sc_valid,
  input logic               sc_uncached,
  input logic               snoop_hit,
  input logic               resv_valid,
  input logic [PADDR_W-1:0] resv_addr,
  input logic               fail_evt,
  input logic               sc_resp_valid,
  input logic               sc_forward,
  input logic [1:0]         sc_code,
  input logic               livelock_warn
);

  localparam logic [PADDR_W-1:0] GMASK = (PADDR_W'(1) << GRAN_LG2) - PADDR_W'(1);

  // input rule: one request kind per cycle
  assert_one_request_input: assert property (@(posedge clk) disable iff (!rst_n)
    !(ll_valid && sc_valid));

  assert_ll_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ll_valid |=> (resv_valid && ((resv_addr & GMASK) == '0)));

  assert_snoop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !ll_valid) |=> !resv_valid);

  assert_bypass_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_uncached) |=> (sc_resp_valid && sc_forward && sc_code == 2'd2));

  assert_bypass_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_uncached && !snoop_hit && resv_valid) |=> resv_valid);

  assert_fail_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (!resv_valid && sc_resp_valid && !sc_forward && sc_code == 2'd0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_resp_valid |-> (!sc_forward && sc_code == 2'd0));

  assert_resp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_resp_valid |-> $past(sc_valid));

  assert_warn_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    livelock_warn |-> (sc_resp_valid && !sc_forward));

  assert_warn_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (livelock_warn && WARN_PERIOD > 1) |=> !livelock_warn);

  assert_snoop_beats_sc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && sc_valid && !sc_uncached) |=> (sc_resp_valid && sc_code == 2'd0));

endmodule

bind llsc_resv_monitor llsc_resv_checker #(
  .PADDR_W(PADDR_W), .GRAN_LG2(GRAN_LG2), .WARN_PERIOD(WARN_PERIOD)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ll_valid     (ll_valid),
  .sc_valid     (sc_valid),
  .sc_uncached  (sc_uncached),
  .snoop_hit    (snoop_hit),
  .resv_valid   (resv_valid),
  .resv_addr    (resv_addr),
  .fail_evt     (fail_evt),
  .sc_resp_valid(sc_resp_valid),
  .sc_forward   (sc_forward),
  .sc_code      (sc_code),
  .livelock_warn(livelock_warn)
);

// File: tb/test_llsc_resv_monitor.sv
`timescale 1ns/1ps
module test_llsc_resv_monitor;

  localparam int AW = 40;
  localparam int PERIOD = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ll_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0;
  logic          sc_valid = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic          sc_uncached = 1'b0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          sc_resp_valid;
  logic          sc_forward;
  logic [1:0]    sc_code;
  logic          livelock_warn;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  bit          m_flag = 0;
  logic [AW-1:0] m_addr = '0;
  int          m_fails = 0;

  always #2.5 clk = ~clk;

  llsc_resv_monitor #(.PADDR_W(AW), .WARN_PERIOD(PERIOD)) i_llsc_resv_monitor (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_resp_valid(sc_resp_valid), .sc_forward(sc_forward),
    .sc_code(sc_code), .livelock_warn(livelock_warn)
  );

  task automatic compare(input string tag, input bit ev, input bit ef, input int ec, input bit ew);
    checks++;
    if (sc_resp_valid !== ev || sc_forward !== ef || int'(sc_code) != ec || livelock_warn !== ew) begin
      errors++;
      $display("FAIL %s: got valid=%0b fwd=%0b code=%0d warn=%0b, expected valid=%0b fwd=%0b code=%0d warn=%0b",
               tag, sc_resp_valid, sc_forward, sc_code, livelock_warn, ev, ef, ec, ew);
    end
  endtask

  task automatic step(input string tag,
                      input bit ll, input logic [AW-1:0] la,
                      input bit sc, input logic [AW-1:0] sa, input bit unc,
                      input bit sn, input logic [AW-1:0] na);
    bit ev, ef, ew, hit;
    int ec;
    ll_valid = ll; ll_addr = la;
    sc_valid = sc; sc_addr = sa; sc_uncached = unc;
    snoop_valid = sn; snoop_addr = na;
    @(posedge clk);
    ev = 0; ef = 0; ec = 0; ew = 0;
    hit = m_flag && sn && (na / 64) == (m_addr / 64);
    if (sc) begin
      ev = 1;
      if (unc) begin
        ef = 1; ec = 2;
      end else if (m_flag && !hit && (sa - sa % 16) == m_addr) begin
        ef = 1; ec = 1; m_fails = 0;
      end else begin
        m_fails++;
        ew = (m_fails % PERIOD) == 0;
        m_flag = 0;
      end
    end
    if (hit) m_flag = 0;
    if (ll) begin
      m_flag = 1;
      m_addr = la - la % 16;
    end
    @(negedge clk);
    compare(tag, ev, ef, ec, ew);
  endtask

  task automatic ll_op(input string tag, input logic [AW-1:0] a);
    step(tag, 1, a, 0, '0, 0, 0, '0);
  endtask
  task automatic sc_op(input string tag, input logic [AW-1:0] a, input bit unc);
    step(tag, 0, '0, 1, a, unc, 0, '0);
  endtask
  task automatic snoop_op(input string tag, input logic [AW-1:0] a);
    step(tag, 0, '0, 0, '0, 0, 1, a);
  endtask

  task automatic do_reset();
    rst_n = 0;
    ll_valid = 0; sc_valid = 0; snoop_valid = 0; sc_uncached = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_flag = 0; m_fails = 0;
    compare("R1 reset outputs", 0, 0, 0, 0);
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 1ns * 0 + 1_000_000ns);
    errors++;
    $display("FAIL R7 watchdog expired: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [AW-1:0] BASE = 40'h12_3456_7800;

  initial begin
    @(negedge clk);
    do_reset();
    sc_op("R1 sc after reset fails", BASE, 0);
    step("R7 idle cycle", 0, '0, 0, '0, 0, 0, '0);

    ll_op("R2 ll", BASE + 7);
    sc_op("R2 sc same granule passes", BASE + 15, 0);
    sc_op("R6 pass keeps reservation", BASE, 0);
    sc_op("R5 other granule fails", BASE + 16, 0);
    sc_op("R5 flag cleared by failure", BASE, 0);

    ll_op("R3 ll", BASE);
    snoop_op("R3 snoop other line", BASE + 64);
    sc_op("R3 other-line snoop harmless", BASE, 0);
    snoop_op("R3 snoop same line", BASE + 40);
    sc_op("R3 same-line snoop clears", BASE, 0);
    snoop_op("R3 snoop with flag clear", BASE);

    ll_op("R4 ll", BASE + 32);
    sc_op("R4 uncached bypass", BASE + 500, 1);
    sc_op("R4 reservation untouched", BASE + 40, 0);

    ll_op("R9 ll", BASE);
    step("R9 snoop+sc same line", 0, '0, 1, BASE, 0, 1, BASE + 48);
    step("R2 ll with same-line snoop", 1, BASE, 0, '0, 0, 1, BASE + 8);
    sc_op("R2 ll beats snoop", BASE + 4, 0);

    // consecutive failures
    for (int i = 0; i < 12; i++) begin
      sc_op("R8 fail run", BASE + 16, 0);
      if (i == 6) sc_op("R8 uncached does not reset count", BASE, 1);
    end
    ll_op("R6 ll", BASE);
    sc_op("R6 pass resets count", BASE, 0);
    for (int i = 0; i < 5; i++) sc_op("R8 fresh run", BASE + 16, 0);

    for (int i = 0; i < 3; i++) sc_op("R1 pre-reset fails", BASE + 16, 0);
    do_reset();
    for (int i = 0; i < 5; i++) sc_op("R1 count cleared by reset", BASE + 16, 0);

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] pick [6] = '{BASE, BASE + 8, BASE + 16, BASE + 40, BASE + 64, BASE + 200};
      int kind = $urandom_range(0, 3);
      bit sn = ($urandom_range(0, 3) == 0);
      logic [AW-1:0] a = pick[$urandom_range(0, 5)];
      logic [AW-1:0] n = pick[$urandom_range(0, 5)];
      case (kind)
        0: step("R7 random ll", 1, a, 0, '0, 0, sn, n);
        1: step("R7 random sc", 0, '0, 1, a, ($urandom_range(0, 5) == 0), sn, n);
        2: step("R7 random snoop", 0, '0, 0, '0, 0, 1, n);
        default: step("R7 random idle", 0, '0, 0, '0, 0, 0, '0);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule